// File: doc/BRIEF.md
# Victim Line Buffer

A small fully associative store that sits between a first-level and a second-level cache. When the first-level cache evicts a line, the line goes into this buffer instead of straight into the second-level cache. Because of this, the eviction write overlaps the second-level read latency rather than coming before it. When the first-level cache misses, it starts its second-level read and presents the same line address to this buffer in the same cycle. If the line is still held here, the buffer answers one cycle later with the data and drops its copy, so a line is never held in two places at once.

Every held line carries an age rank. While all slots are occupied, the buffer stops taking victims and offers its oldest line to the second-level cache over a valid/ready write channel. It does this one line at a time until a slot is free. A lookup that catches the line on offer takes it back, as long as the write has not been accepted.

Top module: `victim_stash`

## Requirements
- R1: After reset the buffer is empty: `victimReady` is 1, `l2WrValid` is 0 and `respValid` is 0.
- R2: A victim is stored when `victimValid` and `victimReady` are both 1 at a clock edge, and up to DEPTH lines (default 8, range 8 to 16) are held.
- R3: A lookup presented in cycle N gives `respValid` = 1 in cycle N+1. On a hit, `respData` carries the stored line data; on a miss it is zero.
- R4: A lookup hit removes the line, so a later lookup of the same address misses.
- R5: While all DEPTH slots are occupied, `victimReady` is 0 and `l2WrValid` is 1.
- R6: The line offered on the write channel is the oldest held line in insertion order. Its address and data stay unchanged while `l2WrReady` is 0 and no lookup is made.
- R7: A write accepted (`l2WrValid` and `l2WrReady` both 1) removes the line. The next cycle then shows `victimReady` = 1 and `l2WrValid` = 0.
- R8: A lookup that hits the offered line in a cycle where `l2WrReady` is 0 returns a hit and withdraws the write.
- R9: A lookup that hits the offered line in the same cycle the write is accepted returns a miss; the line goes to the second-level cache.
- R10: A victim insert and a lookup hit in the same cycle are both carried out. The line count is unchanged, and the slot freed by the hit is usable from the next cycle.
- R11: A lookup of an address not held returns `respHit` = 0 and changes no stored line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| victimValid | input | 1 | Evicted line offered |
| victimAddr | input | ADDR_W | Line address of the evicted line |
| victimData | input | DATA_W | Data of the evicted line |
| victimReady | output | 1 | A free slot exists |
| lookupValid | input | 1 | Lookup request from a first-level miss |
| lookupAddr | input | ADDR_W | Line address looked up |
| respValid | output | 1 | Lookup answer, one cycle after the request |
| respHit | output | 1 | The looked-up line was held and is handed back |
| respData | output | DATA_W | Line data on a hit, zero otherwise |
| l2WrValid | output | 1 | Oldest line offered for writing to the second-level cache |
| l2WrAddr | output | ADDR_W | Address of the offered line |
| l2WrData | output | DATA_W | Data of the offered line |
| l2WrReady | input | 1 | Second-level cache takes the offered line |

## Verification
Two functions can fall in the same cycle and compete for the oldest line: the second-level write handshake and a lookup hit. The bench fills the buffer to capacity and then looks up the oldest address. It does this once with `l2WrReady` low, where a hit and a withdrawn write are expected, and once with it high, where a miss and a completed write are expected. A second collision puts a victim insert and a hit in one cycle. An arithmetic sweep then mixes inserts, lookups and ready patterns against an in-order queue model, which predicts every handshake and answer.

// File: rtl/stash_pkg.sv
package stash_pkg;
  // Slot index width covers the supported depth range up to 16.
  localparam int SLOT_W = 4;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic  insEn;
    slot_t insSlot;
    logic  hitClr;
    slot_t hitSlot;
    logic  drainClr;
    slot_t drainSlot;
  } stashStrb_t;
endpackage

// File: rtl/stash_store.sv
module stash_store
  import stash_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  stashStrb_t        strb,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [DATA_W-1:0] insData,
  input  logic [ADDR_W-1:0] lookAddr,
  output logic [DEPTH-1:0]  validVec,
  output logic              anyMatch,
  output slot_t             matchSlot,
  output slot_t             freeSlot,
  output slot_t             oldSlot,
  output logic [ADDR_W-1:0] oldAddr,
  output logic [DATA_W-1:0] oldData,
  output logic [DATA_W-1:0] respData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] tagArr  [DEPTH];
  logic [DATA_W-1:0] dataArr [DEPTH];
  slot_t             rankArr [DEPTH];
  slot_t             decArr  [DEPTH];
  logic [DEPTH-1:0]  killVec;
  logic [DATA_W-1:0] matchData;
  logic [CNT_W-1:0]  liveCnt, insRank;
  slot_t             hitRank, drainRank;
  logic              insBusy;

  // Associative match, free-slot pick, oldest-line pick.
  always_comb begin
    anyMatch  = 1'b0;
    matchSlot = '0;
    matchData = '0;
    oldSlot   = '0;
    oldAddr   = '0;
    oldData   = '0;
    hitRank   = '0;
    drainRank = '0;
    insBusy   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (validVec[i] && tagArr[i] == lookAddr) begin
        anyMatch  = 1'b1;
        matchSlot = slot_t'(i);
        matchData = dataArr[i];
      end
      if (validVec[i] && rankArr[i] == '0) begin
        oldSlot = slot_t'(i);
        oldAddr = tagArr[i];
        oldData = dataArr[i];
      end
      if (strb.hitSlot == slot_t'(i))   hitRank   = rankArr[i];
      if (strb.drainSlot == slot_t'(i)) drainRank = rankArr[i];
      if (strb.insEn && strb.insSlot == slot_t'(i) && validVec[i]) insBusy = 1'b1;
    end
    freeSlot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validVec[i]) freeSlot = slot_t'(i);
    end
  end

  // Removal and rank shift for surviving lines.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      killVec[i] = (strb.hitClr && strb.hitSlot == slot_t'(i)) ||
                   (strb.drainClr && strb.drainSlot == slot_t'(i));
      decArr[i]  = slot_t'(strb.hitClr && hitRank < rankArr[i]) +
                   slot_t'(strb.drainClr && drainRank < rankArr[i]);
    end
  end

  assign liveCnt = CNT_W'($countones(validVec));
  assign insRank = liveCnt - CNT_W'(strb.hitClr) - CNT_W'(strb.drainClr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      respData <= '0;
    end else begin
      respData <= strb.hitClr ? matchData : '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.insEn && strb.insSlot == slot_t'(i)) validVec[i] <= 1'b1;
        else if (killVec[i])                          validVec[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strb.insEn && strb.insSlot == slot_t'(i)) begin
        tagArr[i]  <= insAddr;
        dataArr[i] <= insData;
        rankArr[i] <= slot_t'(insRank);
      end else if (validVec[i] && !killVec[i]) begin
        rankArr[i] <= rankArr[i] - decArr[i];
      end
    end
  end

  // R2: the control only ever fills a slot that is empty.
  a_r2_insert_free: assert property (@(posedge clk) disable iff (!rstN) !insBusy);

  // R4: a removed line is gone in the following cycle.
  a_r4_removed_gone: assert property (@(posedge clk) disable iff (!rstN)
    rstN && (|killVec) |=> (validVec & $past(killVec)) == '0);

  // R10: line count follows inserts and removals exactly.
  a_r10_count_track: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> CNT_W'($countones(validVec)) == $past(insRank) + CNT_W'($past(strb.insEn)));

  // R9: drain and hit never remove the same slot together.
  a_r9_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.hitClr && strb.drainClr |-> strb.hitSlot != strb.drainSlot);
endmodule

// File: rtl/stash_ctrl.sv
module stash_ctrl
  import stash_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             victimValid,
  input  logic             lookupValid,
  input  logic             l2WrReady,
  input  logic [DEPTH-1:0] validVec,
  input  logic             anyMatch,
  input  slot_t            matchSlot,
  input  slot_t            freeSlot,
  input  slot_t            oldSlot,
  output stashStrb_t       strb,
  output logic             victimReady,
  output logic             l2WrValid,
  output logic             respValid,
  output logic             respHit
);
  logic full, drainAcc, lookHit, hitOnOld;

  assign full        = &validVec;
  assign victimReady = !full;
  assign l2WrValid   = full;
  assign drainAcc    = full && l2WrReady;
  assign lookHit     = lookupValid && anyMatch;
  assign hitOnOld    = lookHit && matchSlot == oldSlot;

  always_comb begin
    strb.insEn     = victimValid && !full;
    strb.insSlot   = freeSlot;
    // An accepted write takes the oldest line; a lookup on it then misses.
    strb.hitClr    = lookHit && !(drainAcc && hitOnOld);
    strb.hitSlot   = matchSlot;
    strb.drainClr  = drainAcc;
    strb.drainSlot = oldSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
    end else begin
      respValid <= lookupValid;
      respHit   <= strb.hitClr;
    end
  end

  // R3: every lookup is answered in the next cycle, and only then.
  a_r3_resp_next: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> respValid == $past(lookupValid));

  // R6: an unaccepted offer persists while nothing else frees a slot.
  a_r6_offer_held: assert property (@(posedge clk) disable iff (!rstN)
    l2WrValid && !l2WrReady && !lookupValid |=> l2WrValid);

  // R8: a hit on the offered line withdraws the write.
  a_r8_cancel: assert property (@(posedge clk) disable iff (!rstN)
    l2WrValid && !l2WrReady && lookupValid && anyMatch && matchSlot == oldSlot
    |=> respHit && !l2WrValid);

  // R9: an accepted write wins over a same-cycle lookup of that line.
  a_r9_accept_wins: assert property (@(posedge clk) disable iff (!rstN)
    l2WrValid && l2WrReady && lookupValid && anyMatch && matchSlot == oldSlot
    |=> respValid && !respHit);
endmodule

// File: rtl/victim_stash.sv
module victim_stash
  import stash_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              victimValid,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic [DATA_W-1:0] victimData,
  output logic              victimReady,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic              l2WrValid,
  output logic [ADDR_W-1:0] l2WrAddr,
  output logic [DATA_W-1:0] l2WrData,
  input  logic              l2WrReady
);
  stashStrb_t       strb;
  logic [DEPTH-1:0] validVec;
  logic             anyMatch;
  slot_t            matchSlot, freeSlot, oldSlot;

  stash_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .victimValid(victimValid), .lookupValid(lookupValid),
    .l2WrReady(l2WrReady), .validVec(validVec), .anyMatch(anyMatch),
    .matchSlot(matchSlot), .freeSlot(freeSlot), .oldSlot(oldSlot), .strb(strb),
    .victimReady(victimReady), .l2WrValid(l2WrValid), .respValid(respValid),
    .respHit(respHit)
  );

  stash_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .insAddr(victimAddr), .insData(victimData),
    .lookAddr(lookupAddr), .validVec(validVec), .anyMatch(anyMatch),
    .matchSlot(matchSlot), .freeSlot(freeSlot), .oldSlot(oldSlot),
    .oldAddr(l2WrAddr), .oldData(l2WrData), .respData(respData)
  );

  // R6: the offered line does not change while it waits and no lookup runs.
  a_r6_offer_stable: assert property (@(posedge clk) disable iff (!rstN)
    l2WrValid && !l2WrReady && !lookupValid |=> $stable(l2WrAddr) && $stable(l2WrData));
endmodule

// File: tb/victim_stash_tb.sv
`timescale 1ns/1ps
module victim_stash_tb;
  localparam int DEPTH = 8;
  localparam int AW    = 12;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          victimValid = 1'b0, lookupValid = 1'b0, l2WrReady = 1'b0;
  logic [AW-1:0] victimAddr = '0, lookupAddr = '0;
  logic [DW-1:0] victimData = '0;
  logic          victimReady, respValid, respHit, l2WrValid;
  logic [DW-1:0] respData, l2WrData;
  logic [AW-1:0] l2WrAddr;

  int nChecks = 0, nFail = 0;
  logic [AW-1:0] mq[$];
  logic pendV = 1'b0, pendHit = 1'b0;
  logic [AW-1:0] pendAddr = '0;
  logic obsReady, obsL2V, obsHit;
  logic [DW-1:0] obsData;
  logic [AW-1:0] nextA;
  bit done = 0;

  always #4 clk = ~clk;

  victim_stash #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .victimValid(victimValid), .victimAddr(victimAddr),
    .victimData(victimData), .victimReady(victimReady), .lookupValid(lookupValid),
    .lookupAddr(lookupAddr), .respValid(respValid), .respHit(respHit),
    .respData(respData), .l2WrValid(l2WrValid), .l2WrAddr(l2WrAddr),
    .l2WrData(l2WrData), .l2WrReady(l2WrReady)
  );

  function automatic logic [DW-1:0] dataOf(input logic [AW-1:0] a);
    return 32'h5A00_0000 ^ ({20'b0, a} * 32'h0000_9E37);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus checked against an in-order queue model.
  task automatic step(input logic vV, input logic [AW-1:0] vA, input logic lV,
                      input logic [AW-1:0] lA, input logic wR);
    int sz, idx;
    logic dAcc, hit;
    victimValid = vV; victimAddr = vA; victimData = dataOf(vA);
    lookupValid = lV; lookupAddr = lA; l2WrReady = wR;
    @(negedge clk);
    sz = mq.size();
    obsReady = victimReady; obsL2V = l2WrValid; obsHit = respHit; obsData = respData;
    check("R2 ready", victimReady, 64'(sz < DEPTH));
    check("R5 full offer", l2WrValid, 64'(sz == DEPTH));
    if (sz == DEPTH) begin
      check("R6 oldest addr", l2WrAddr, mq[0]);
      check("R6 oldest data", l2WrData, dataOf(mq[0]));
    end
    check("R3 resp valid", respValid, pendV);
    if (pendV) begin
      check("R4 R11 hit flag", respHit, pendHit);
      check("R3 resp data", respData, pendHit ? dataOf(pendAddr) : '0);
    end
    idx = -1;
    for (int i = 0; i < sz; i++) if (mq[i] == lA) idx = i;
    dAcc = (sz == DEPTH) && wR;
    hit  = lV && idx >= 0 && !(dAcc && idx == 0);
    if (dAcc) begin void'(mq.pop_front()); idx--; end
    if (hit) mq.delete(idx);
    if (vV && sz < DEPTH) mq.push_back(vA);
    pendV = lV; pendHit = hit; pendAddr = lA;
    @(posedge clk); #1;
    victimValid = 1'b0; lookupValid = 1'b0; l2WrReady = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 ready", victimReady, 1);
    check("R1 offer", l2WrValid, 0);
    check("R1 resp", respValid, 0);
    @(posedge clk); #1;

    // R2 R5: fill to capacity with the write side stalled.
    for (int i = 0; i < DEPTH; i++) step(1'b1, AW'(12'h100 + i), 1'b0, '0, 1'b0);
    nextA = 12'h108;
    // R6: offer held over stalled cycles.
    repeat (3) idle();
    check("R5 blocked", obsReady, 0);

    // R4: hit a middle line, then look it up again.
    step(1'b0, '0, 1'b1, 12'h103, 1'b0);
    step(1'b0, '0, 1'b1, 12'h103, 1'b0);
    idle();
    check("R4 second lookup", obsHit, 0);

    // R11: an absent address.
    step(1'b0, '0, 1'b1, 12'hFFF, 1'b0);
    idle();
    check("R11 miss", obsHit, 0);
    check("R11 miss data", obsData, 0);

    // R8: fill, then take back the offered line before acceptance.
    step(1'b1, nextA, 1'b0, '0, 1'b0); nextA++;
    step(1'b0, '0, 1'b1, 12'h100, 1'b0);
    idle();
    check("R8 hit", obsHit, 1);
    check("R8 withdrawn", obsL2V, 0);

    // R9: lookup of the offered line while the write is accepted.
    step(1'b1, nextA, 1'b0, '0, 1'b0); nextA++;
    step(1'b0, '0, 1'b1, 12'h101, 1'b1);
    idle();
    check("R9 miss", obsHit, 0);
    check("R7 ready again", obsReady, 1);
    check("R7 offer dropped", obsL2V, 0);

    // R7: plain acceptance.
    step(1'b1, nextA, 1'b0, '0, 1'b0); nextA++;
    step(1'b0, '0, 1'b0, '0, 1'b1);
    idle();
    check("R7 after accept", obsReady, 1);

    // R10: insert and hit together at one below capacity.
    step(1'b1, nextA, 1'b1, 12'h105, 1'b0); nextA++;
    idle();
    check("R10 hit", obsHit, 1);
    check("R10 count", obsReady, 1);
    step(1'b1, nextA, 1'b0, '0, 1'b0); nextA++;
    idle();
    check("R10 refilled", obsL2V, 1);

    // Sweep: mixed inserts, lookups and ready patterns.
    for (int k = 0; k < 600; k++) begin
      logic vV, lV, wR, acc;
      logic [AW-1:0] lA;
      vV  = (k % 3) != 0;
      lV  = (k % 2) == 0;
      wR  = ((k % 4) == 1) || ((k % 7) == 0);
      lA  = nextA - AW'(1 + (k % 13));
      acc = vV && mq.size() < DEPTH;
      step(vV, nextA, lV, lA, wR);
      if (acc) nextA++;
    end
    idle();

    done = 1;
    finishRun();
  end
endmodule